// File: doc/BRIEF.md
# Time-Shared Multichannel FIR Filter

This block filters several independent sample streams that share one data wire. Samples arrive interleaved, one channel after another, inside a group. A start-of-packet marker goes with the channel 0 sample and an end-of-packet marker goes with the last channel's sample. Idle cycles may fall between groups, so valid beats can be very sparse. One multiply-accumulate unit serves every channel. Each channel has its own history of past samples, so the channels never mix. The coefficient set is fixed at elaboration. By default it has seven taps: 1, 5, 5, 5, 5, 5, 1.

The input is a valid/ready stream. The block accepts a beat on a rising clock edge when `in_valid` and `in_ready` are both high. While `in_ready` is low, the sender holds its beat. `in_ready` is low while the block is held in reset and for a short guard window after reset is released. It is also low while a sum is being accumulated. The output stream has no back-pressure. Each result is a one-cycle `out_valid` pulse with markers in the same channel order as the input. The sum is carried at full width, so nothing is truncated.

If the framing markers do not match the channel position, the block pulses `frame_err` and drops that beat. It then ignores input until the next start-of-packet.

Top module: `tdm_fir`

## Requirements
- R1: While `rst_n` is low, `in_ready`, `out_valid` and `frame_err` are 0. Reset clears every channel's history, so the first results after a reset depend only on samples accepted after it.
- R2: After `rst_n` rises, `in_ready` stays low for exactly GUARD (default 4) rising edges. A beat offered during that window is never taken into any history.
- R3: A unit impulse (value 1) on one channel, followed by zeros, produces exactly 1, 5, 5, 5, 5, 5, 1 on that channel's next seven results.
- R4: An impulse on one channel leaves every other channel's results at zero.
- R5: The impulse response is the same whether groups are sent back to back or separated by more than a hundred idle cycles.
- R6: Each accepted beat produces one `out_valid` pulse, one cycle long, NTAPS (default 7) rising edges after the accepting edge. `out_sop` is high only on channel 0 results and `out_eop` only on channel NCH-1 results.
- R7: After each accepted beat, `in_ready` is low for exactly NTAPS cycles.
- R8: `out_data` is a two's-complement value of DW plus log2 of the coefficient magnitude sum, default 21 bits. Full-scale inputs of -32768 and +32767 held on all taps give -884736 and +884709.
- R9: An accepted beat is a framing error in three cases: `in_eop` disagrees with whether the beat is channel NCH-1, `in_sop` is missing on an expected channel 0, or `in_sop` arrives early. On an error, `frame_err` pulses one cycle after the accepting edge, the beat is dropped, and non-start beats are then ignored without error until a beat with `in_sop`.
- R10: For arbitrary data, each result equals the sum over taps k of coefficient k times the channel's k-th most recent sample, where k=0 is the newest sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can take a beat this edge |
| in_data | input | DW | Signed input sample |
| in_sop | input | 1 | Beat is channel 0 (group start) |
| in_eop | input | 1 | Beat is channel NCH-1 (group end) |
| out_valid | output | 1 | Result pulse |
| out_data | output | DW+log2(coef sum) | Signed filtered result |
| out_sop | output | 1 | Result belongs to channel 0 |
| out_eop | output | 1 | Result belongs to channel NCH-1 |
| frame_err | output | 1 | One-cycle pulse on a framing error |

## Verification
Every result is due on the NTAPS-th rising edge after the edge that accepted its beat. A `frame_err` pulse is due on the edge right after the accepting edge. The driver records the edge count when each beat is accepted and pushes the expected value, the expected markers and the due edge into a scoreboard. The monitor samples on falling edges and compares each `out_valid` pulse with the next entry, including the edge on which it appeared. The ready-low window after reset and after each beat is measured on falling edges, starting from the release or accepting edge.

// File: rtl/tdm_fir_pkg.sv
package tdm_fir_pkg;
  localparam int CW = 4;

  // Fixed coefficient set: 1 at both ends, 5 in between
  function automatic logic signed [CW-1:0] coef_at(input int idx, input int ntaps);
    if (idx == 0 || idx == ntaps - 1) return CW'(1);
    return CW'(5);
  endfunction

  function automatic int coef_mag_sum(input int ntaps);
    int s;
    logic signed [CW-1:0] c;
    s = 0;
    for (int k = 0; k < ntaps; k++) begin
      c = coef_at(k, ntaps);
      s += (c < 0) ? -int'(c) : int'(c);
    end
    return s;
  endfunction
endpackage

// File: rtl/tdm_fir_frame.sv
module tdm_fir_frame #(
  parameter int NCH   = 2,
  parameter int GUARD = 4,
  parameter int CHW   = 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic           in_sop,
  input  logic           in_eop,
  input  logic           busy,
  output logic           in_ready,
  output logic           start,
  output logic [CHW-1:0] start_ch,
  output logic           frame_err
);
  localparam int GW = $clog2(GUARD + 1);

  logic [GW-1:0]  gcnt;
  logic           guard_done, synced, beat, take, bad_sop, bad_eop, bad;
  logic [CHW-1:0] cur_ch, eff_ch;

  always_comb begin
    guard_done = (gcnt == GW'(GUARD));
    in_ready   = guard_done && !busy;
    beat       = in_valid && in_ready;
    eff_ch     = in_sop ? '0 : cur_ch;
    take       = beat && (synced || in_sop);
    bad_sop    = synced && (in_sop != (cur_ch == '0));
    bad_eop    = in_eop != (eff_ch == CHW'(NCH - 1));
    bad        = take && (bad_sop || bad_eop);
    start      = take && !bad;
    start_ch   = eff_ch;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gcnt      <= '0;
      synced    <= 1'b0;
      cur_ch    <= '0;
      frame_err <= 1'b0;
    end else begin
      if (!guard_done) gcnt <= gcnt + GW'(1);
      frame_err <= bad;
      if (start) begin
        synced <= 1'b1;
        cur_ch <= (eff_ch == CHW'(NCH - 1)) ? '0 : eff_ch + CHW'(1);
      end else if (bad) begin
        synced <= 1'b0;
        cur_ch <= '0;
      end
    end
  end

  // R9: an error pulse always follows an accepted beat
  a_r9_err_after_beat: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> $past(in_valid && in_ready));
endmodule

// File: rtl/tdm_fir_hist.sv
module tdm_fir_hist #(
  parameter int NCH   = 2,
  parameter int NTAPS = 7,
  parameter int DW    = 16,
  parameter int CHW   = 1,
  parameter int TW    = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [CHW-1:0] wr_ch,
  input  logic [DW-1:0]  wr_data,
  input  logic [CHW-1:0] rd_ch,
  input  logic [TW-1:0]  rd_tap,
  output logic [DW-1:0]  rd_data
);
  logic [DW-1:0] line [NCH][NTAPS];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int k = 0; k < NTAPS; k++) line[c][k] <= '0;
      end else if (wr_en && wr_ch == CHW'(c)) begin
        line[c][0] <= wr_data;
        for (int k = 1; k < NTAPS; k++) line[c][k] <= line[c][k-1];
      end
    end
  end

  assign rd_data = line[rd_ch][rd_tap];
endmodule

// File: rtl/tdm_fir_mac.sv
module tdm_fir_mac #(
  parameter int NCH   = 2,
  parameter int NTAPS = 7,
  parameter int DW    = 16,
  parameter int AW    = 21,
  parameter int CHW   = 1,
  parameter int TW    = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [CHW-1:0] start_ch,
  input  logic [DW-1:0]  rd_data,
  output logic           busy,
  output logic [CHW-1:0] rd_ch,
  output logic [TW-1:0]  rd_tap,
  output logic           out_valid,
  output logic [AW-1:0]  out_data,
  output logic           out_sop,
  output logic           out_eop
);
  logic signed [AW-1:0] acc, prod, x_ext, c_ext;
  logic [CHW-1:0]       out_ch;

  always_comb begin
    x_ext = AW'($signed(rd_data));
    c_ext = AW'(tdm_fir_pkg::coef_at(int'(rd_tap), NTAPS));
    prod  = x_ext * c_ext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      rd_ch     <= '0;
      rd_tap    <= '0;
      acc       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_sop   <= 1'b0;
      out_eop   <= 1'b0;
      out_ch    <= '0;
    end else begin
      out_valid <= 1'b0;
      if (start) begin
        busy   <= 1'b1;
        rd_ch  <= start_ch;
        rd_tap <= '0;
        acc    <= '0;
      end else if (busy) begin
        if (rd_tap == TW'(NTAPS - 1)) begin
          busy      <= 1'b0;
          out_valid <= 1'b1;
          out_data  <= acc + prod;
          out_ch    <= rd_ch;
          out_sop   <= (rd_ch == '0);
          out_eop   <= (rd_ch == CHW'(NCH - 1));
        end else begin
          acc    <= acc + prod;
          rd_tap <= rd_tap + TW'(1);
        end
      end
    end
  end

  // R7: a new sum never starts while one is running
  a_r7_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
  // R6: results are single-cycle pulses
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  // R6: results only end a running sum
  a_r6_ends_sum: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(busy));
  // R6: marker/channel agreement
  a_r6_sop_ch0: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sop) |-> out_ch == '0);
  a_r6_eop_last: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_eop) |-> out_ch == CHW'(NCH - 1));
endmodule

// File: rtl/tdm_fir.sv
module tdm_fir #(
  parameter int NCH   = 2,
  parameter int DW    = 16,
  parameter int NTAPS = 7,
  parameter int GUARD = 4,
  localparam int AW   = DW + $clog2(tdm_fir_pkg::coef_mag_sum(NTAPS) + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          in_sop,
  input  logic          in_eop,
  output logic          out_valid,
  output logic [AW-1:0] out_data,
  output logic          out_sop,
  output logic          out_eop,
  output logic          frame_err
);
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int TW  = (NTAPS > 1) ? $clog2(NTAPS) : 1;

  logic           start, busy;
  logic [CHW-1:0] start_ch, rd_ch;
  logic [TW-1:0]  rd_tap;
  logic [DW-1:0]  rd_data;

  tdm_fir_frame #(.NCH(NCH), .GUARD(GUARD), .CHW(CHW)) u_frame (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
    .in_eop(in_eop), .busy(busy), .in_ready(in_ready), .start(start),
    .start_ch(start_ch), .frame_err(frame_err)
  );

  tdm_fir_hist #(.NCH(NCH), .NTAPS(NTAPS), .DW(DW), .CHW(CHW), .TW(TW)) u_hist (
    .clk(clk), .rst_n(rst_n), .wr_en(start), .wr_ch(start_ch),
    .wr_data(in_data), .rd_ch(rd_ch), .rd_tap(rd_tap), .rd_data(rd_data)
  );

  tdm_fir_mac #(.NCH(NCH), .NTAPS(NTAPS), .DW(DW), .AW(AW), .CHW(CHW), .TW(TW)) u_mac (
    .clk(clk), .rst_n(rst_n), .start(start), .start_ch(start_ch),
    .rd_data(rd_data), .busy(busy), .rd_ch(rd_ch), .rd_tap(rd_tap),
    .out_valid(out_valid), .out_data(out_data), .out_sop(out_sop),
    .out_eop(out_eop)
  );

  // R1: nothing leaves the block while it is held in reset
  a_r1_quiet_in_reset: assert property (@(posedge clk)
    !rst_n |-> (!in_ready && !out_valid && !frame_err));
endmodule

// File: tb/tdm_fir_bench.sv
module tdm_fir_bench;
  localparam int NCH = 2, DW = 16, NTAPS = 7, GUARD = 4, AW = 21;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_sop = 0, in_eop = 0;
  logic [DW-1:0] in_data = '0;
  logic in_ready, out_valid, out_sop, out_eop, frame_err;
  logic [AW-1:0] out_data;

  always #2.5 clk = ~clk;

  tdm_fir u_tdm_fir (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop),
    .out_valid(out_valid), .out_data(out_data), .out_sop(out_sop),
    .out_eop(out_eop), .frame_err(frame_err)
  );

  typedef struct { int data; bit sop; bit eop; longint due; string req; } item_t;
  item_t sb[$];
  int checks = 0, fails = 0;
  longint cyc = 0;
  string cur_req = "R3";
  int mh [NCH][NTAPS];
  int cf [NTAPS] = '{1, 5, 5, 5, 5, 5, 1};

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int c = 0; c < NCH; c++) for (int k = 0; k < NTAPS; k++) mh[c][k] = 0;
  endtask

  // Driver: offers a beat, records acceptance, pushes the expected result
  task automatic send(bit sop, bit eop, int data, bit good, int ch);
    item_t it;
    int s;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1; in_sop = sop; in_eop = eop; in_data = DW'(data);
    if (good) begin
      for (int k = NTAPS - 1; k > 0; k--) mh[ch][k] = mh[ch][k-1];
      mh[ch][0] = data;
      s = 0;
      for (int k = 0; k < NTAPS; k++) s += cf[k] * mh[ch][k];
      it.data = s; it.sop = (ch == 0); it.eop = (ch == NCH - 1);
      it.due = cyc + 1 + NTAPS; it.req = cur_req;
      sb.push_back(it);
    end
    @(negedge clk);
    in_valid = 0; in_sop = 0; in_eop = 0;
  endtask

  task automatic group(int d0, int d1);
    send(1, 0, d0, 1, 0);
    send(0, 1, d1, 1, 1);
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
    repeat (NTAPS + 2) @(negedge clk);
  endtask

  // Monitor: compares each result with the scoreboard head
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (sb.size() == 0) begin
        check(0, "R6", "unexpected result", longint'($signed(out_data)), 0);
      end else begin
        item_t e;
        e = sb.pop_front();
        check(int'($signed(out_data)) == e.data, e.req, "out_data",
              longint'($signed(out_data)), e.data);
        check(cyc == e.due, "R6", "result cycle", cyc, e.due);
        check(out_sop == e.sop && out_eop == e.eop, "R6", "markers",
              {out_sop, out_eop}, {e.sop, e.eop});
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "R1", "watchdog expired", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n;
    model_clear();
    // R1: quiet while in reset
    repeat (3) @(negedge clk);
    check(!in_ready && !out_valid && !frame_err, "R1", "outputs in reset",
          {in_ready, out_valid, frame_err}, 0);
    // R2: guard window; a beat is offered throughout and must not be taken
    in_valid = 1; in_sop = 1; in_eop = 0; in_data = DW'(100);
    rst_n = 1;
    n = 0;
    @(negedge clk);
    while (!in_ready && n < 50) begin n++; @(negedge clk); end
    in_valid = 0; in_sop = 0; in_data = '0;
    check(n + 1 == GUARD, "R2", "guard cycles", n + 1, GUARD);

    // R3: impulse on channel 0; R2 also checked: the offered 100 never shows
    cur_req = "R3";
    group(1, 0);
    for (int i = 0; i < NTAPS - 1; i++) group(0, 0);
    // R7: ready-low window after one beat
    send(1, 0, 0, 1, 0);
    n = 0;
    while (!in_ready && n < 50) begin n++; @(negedge clk); end
    check(n == NTAPS, "R7", "ready low cycles", n, NTAPS);
    send(0, 1, 0, 1, 1);
    drain();

    // R4: impulse on channel 1 only, channel 0 stays zero
    cur_req = "R4";
    group(0, 1);
    for (int i = 0; i < NTAPS - 1; i++) group(0, 0);
    drain();

    // R5: sparse groups, 120 idle cycles between them
    cur_req = "R5";
    group(1, 0);
    for (int i = 0; i < NTAPS; i++) begin
      repeat (120) @(negedge clk);
      group(0, 0);
    end
    drain();

    // R10: arbitrary data on both channels
    cur_req = "R10";
    for (int i = 0; i < 12; i++) group((i * 377) % 2000 - 1000, 700 - i * 91);
    drain();

    // R8: full-scale inputs held on all taps
    cur_req = "R8";
    for (int i = 0; i < NTAPS + 1; i++) group(-32768, 32767);
    drain();

    // R9: end marker on channel 0 is an error
    cur_req = "R9";
    send(1, 1, 555, 0, 0);
    check(frame_err == 1, "R9", "err on bad eop", frame_err, 1);
    @(negedge clk);
    check(frame_err == 0, "R9", "err one cycle", frame_err, 0);
    send(0, 1, 777, 0, 1);
    check(frame_err == 0, "R9", "no err while unsynced", frame_err, 0);
    group(0, 0);
    send(1, 0, 3, 1, 0);
    send(0, 0, 888, 0, 1);
    check(frame_err == 1, "R9", "err on missing eop", frame_err, 1);
    group(0, 0);
    drain();
    check(sb.size() == 0, "R9", "scoreboard empty", sb.size(), 0);

    // R1: a mid-run reset clears the histories
    cur_req = "R1";
    group(900, -900);
    drain();
    @(negedge clk); rst_n = 0; model_clear();
    @(negedge clk);
    check(!in_ready && !out_valid, "R1", "quiet in second reset", {in_ready, out_valid}, 0);
    rst_n = 1;
    group(1, 1);
    for (int i = 0; i < NTAPS - 1; i++) group(0, 0);
    drain();
    check(sb.size() == 0, "R6", "all results seen", sb.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule